// File: doc/BRIEF.md
# Pipelined Signed Integer Divider

This block divides a 32-bit two's complement dividend by a 16-bit two's complement divisor and returns a 32-bit two's complement quotient. The quotient is truncated toward zero. A status flag reports a zero divisor, and a second flag reports a division that left a nonzero remainder. The operands need no prenormalisation. Any dividend and any nonzero divisor are accepted.

Each operand has its own holding register with an active-low load strobe. A register that is not strobed keeps its value and is used again by every following division. A divisor written once can therefore serve a whole stream of dividends, which gives division by a constant. The pipeline has a fixed depth. It starts a new division from the held operands on every clock, so after the fill time one result leaves per clock.

The core works on operand magnitudes in sixteen steps, and each step resolves two quotient bits by the non-restoring method. A final stage fixes the sign and derives the remainder flag. The result then passes through a registered output stage. An active-low output enable is itself registered. In this model a high-impedance bus is shown as a drive-enable signal next to the data, and the data reads as zero while the bus is not driven.

Top module: `pipe_sdiv`

## Requirements
- R1: The dividend register takes `dividendIn` on a rising edge where `dividendLoadN` is 0. On any other edge it keeps its previous value, whatever `dividendIn` does.
- R2: The divisor register takes `divisorIn` on a rising edge where `divisorLoadN` is 0, and it does so independently of the dividend register. A divisor loaded once is used for every later division until it is loaded again.
- R3: The result for the register contents present after edge n appears on the outputs after edge n+19. A new result appears after every edge.
- R4: For a nonzero divisor, `quotient` is the signed quotient of the two register values, truncated toward zero, for every combination of operand signs.
- R5: For a nonzero divisor, `remNonZero` is 1 exactly when the dividend is not an exact multiple of the divisor.
- R6: `divZero` is 1 exactly when the divisor was zero, whatever the dividend was. The quotient and `remNonZero` are unspecified for such a result.
- R7: The dividend 0x80000000 divided by the divisor 0xFFFF gives `quotient` 0x80000000 with `remNonZero` 0.
- R8: When the dividend magnitude is smaller than the divisor magnitude, `quotient` is 0, and `remNonZero` is 1 unless the dividend is zero.
- R9: `outDriven` after an edge equals the inverse of the `outEnN` value sampled at that edge. While `outDriven` is 0, `quotient`, `divZero` and `remNonZero` read 0.
- R10: A synchronous active-high `rst` clears both operand registers to zero, drops `outDriven` to 0 and empties the pipeline. The outputs read 0 until the first result, which arrives 19 edges after the first edge with `rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dividendIn | input | 32 | Dividend operand, two's complement |
| dividendLoadN | input | 1 | Dividend register load strobe, active low |
| divisorIn | input | 16 | Divisor operand, two's complement |
| divisorLoadN | input | 1 | Divisor register load strobe, active low |
| outEnN | input | 1 | Output enable, active low, takes effect one edge later |
| quotient | output | 32 | Signed quotient, truncated toward zero |
| divZero | output | 1 | The result came from a zero divisor |
| remNonZero | output | 1 | The division left a nonzero remainder |
| outDriven | output | 1 | Stands in for the bus being driven (not high impedance) |

## Verification
Several things can change at the same edge: a result leaving the pipeline, the registered output enable switching, and an operand register being loaded or holding a constant while the other one streams. The bench provokes this by toggling `outEnN` at random in the middle of a dense stream. It also holds one operand register through many cycles while the other is written every cycle. A behavioural model keeps its own copies of the registers and a 19-deep queue of expected results. On every clock the model decides whether the bus must read zero or must show a particular quotient and flag pair, and the outputs are compared against that.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  parameter int DIVIDEND_W     = 32;
  parameter int DIVISOR_W      = 16;
  parameter int BITS_PER_STAGE = 2;

  localparam int NUM_STEPS = DIVIDEND_W / BITS_PER_STAGE;
  localparam int PREM_W    = DIVISOR_W + 2;
  localparam int LATENCY   = NUM_STEPS + 3;

  typedef struct packed {
    logic [DIVIDEND_W-1:0]    shift;   // dividend bits out at top, quotient bits in at bottom
    logic [PREM_W-1:0]        prem;    // signed partial remainder
    logic [DIVISOR_W-1:0]     dmag;    // divisor magnitude
    logic                     negate;
    logic                     divZero;
  } lane_t;

  typedef struct packed {
    logic clear;
    logic loadDividend;
    logic loadDivisor;
    logic resultLoad;
  } strobe_t;
endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    dividendLoadN,
  input  logic    divisorLoadN,
  input  logic    outEnN,
  output strobe_t strobes,
  output logic    outDriven
);
  logic [LATENCY-1:0] validPipe;
  logic               oeHeld;

  always_ff @(posedge clk) begin
    if (rst) begin
      validPipe <= '0;
      oeHeld    <= 1'b1;
    end else begin
      validPipe <= {validPipe[LATENCY-2:0], 1'b1};
      oeHeld    <= outEnN;
    end
  end

  always_comb begin
    strobes.clear        = rst;
    strobes.loadDividend = ~dividendLoadN;
    strobes.loadDivisor  = ~divisorLoadN;
    strobes.resultLoad   = validPipe[LATENCY-1];
  end

  assign outDriven = ~oeHeld;
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step
  import sdiv_pkg::*;
(
  input  lane_t laneIn,
  output lane_t laneOut
);
  logic [PREM_W-1:0] dExt;
  logic [PREM_W-1:0] shifted;

  assign dExt = PREM_W'(laneIn.dmag);

  always_comb begin
    laneOut = laneIn;
    shifted = '0;
    for (int i = 0; i < BITS_PER_STAGE; i++) begin
      shifted = {laneOut.prem[PREM_W-2:0], laneOut.shift[DIVIDEND_W-1]};
      if (laneOut.prem[PREM_W-1]) laneOut.prem = shifted + dExt;
      else                        laneOut.prem = shifted - dExt;
      laneOut.shift = {laneOut.shift[DIVIDEND_W-2:0], ~laneOut.prem[PREM_W-1]};
    end
  end
endmodule

// File: rtl/sdiv_datapath.sv
module sdiv_datapath
  import sdiv_pkg::*;
(
  input  logic                  clk,
  input  strobe_t               strobes,
  input  logic [DIVIDEND_W-1:0] dividendIn,
  input  logic [DIVISOR_W-1:0]  divisorIn,
  output logic [DIVIDEND_W-1:0] quotientReg,
  output logic                  divZeroReg,
  output logic                  remReg,
  output logic [DIVIDEND_W-1:0] heldDividend,
  output logic [DIVISOR_W-1:0]  heldDivisor
);
  lane_t lanes   [NUM_STEPS+1];
  lane_t stepOut [NUM_STEPS];

  logic [DIVIDEND_W-1:0] fixQ;
  logic                  fixRem;
  logic                  fixDz;
  logic [PREM_W-1:0]     remCorr;
  logic [PREM_W-1:0]     lastDExt;

  // operand holding registers
  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      heldDividend <= '0;
      heldDivisor  <= '0;
    end else begin
      if (strobes.loadDividend) heldDividend <= dividendIn;
      if (strobes.loadDivisor)  heldDivisor  <= divisorIn;
    end
  end

  genvar s;
  generate
    for (s = 0; s < NUM_STEPS; s++) begin : g_step
      sdiv_step u_step (.laneIn(lanes[s]), .laneOut(stepOut[s]));
    end
  endgenerate

  // magnitude stage and step array registers
  always_ff @(posedge clk) begin
    lanes[0].shift   <= heldDividend[DIVIDEND_W-1] ? -heldDividend : heldDividend;
    lanes[0].prem    <= '0;
    lanes[0].dmag    <= heldDivisor[DIVISOR_W-1] ? -heldDivisor : heldDivisor;
    lanes[0].negate  <= heldDividend[DIVIDEND_W-1] ^ heldDivisor[DIVISOR_W-1];
    lanes[0].divZero <= (heldDivisor == '0);
    for (int k = 0; k < NUM_STEPS; k++) lanes[k+1] <= stepOut[k];
  end

  // sign fix and remainder detection
  assign lastDExt = PREM_W'(lanes[NUM_STEPS].dmag);
  assign remCorr  = lanes[NUM_STEPS].prem[PREM_W-1] ? lanes[NUM_STEPS].prem + lastDExt
                                                    : lanes[NUM_STEPS].prem;

  always_ff @(posedge clk) begin
    fixQ   <= lanes[NUM_STEPS].negate ? -lanes[NUM_STEPS].shift : lanes[NUM_STEPS].shift;
    fixRem <= (remCorr != '0);
    fixDz  <= lanes[NUM_STEPS].divZero;
  end

  // output register
  always_ff @(posedge clk) begin
    if (strobes.clear || !strobes.resultLoad) begin
      quotientReg <= '0;
      divZeroReg  <= 1'b0;
      remReg      <= 1'b0;
    end else begin
      quotientReg <= fixQ;
      divZeroReg  <= fixDz;
      remReg      <= fixRem;
    end
  end
endmodule

// File: rtl/pipe_sdiv.sv
module pipe_sdiv
  import sdiv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DIVIDEND_W-1:0] dividendIn,
  input  logic                  dividendLoadN,
  input  logic [DIVISOR_W-1:0]  divisorIn,
  input  logic                  divisorLoadN,
  input  logic                  outEnN,
  output logic [DIVIDEND_W-1:0] quotient,
  output logic                  divZero,
  output logic                  remNonZero,
  output logic                  outDriven
);
  strobe_t               strobes;
  logic [DIVIDEND_W-1:0] quotientReg;
  logic                  divZeroReg;
  logic                  remReg;
  logic [DIVIDEND_W-1:0] heldDividend;
  logic [DIVISOR_W-1:0]  heldDivisor;
  logic                  resultLoad;

  sdiv_ctrl u_ctrl (
    .clk(clk), .rst(rst), .dividendLoadN(dividendLoadN), .divisorLoadN(divisorLoadN),
    .outEnN(outEnN), .strobes(strobes), .outDriven(outDriven)
  );

  sdiv_datapath u_dp (
    .clk(clk), .strobes(strobes), .dividendIn(dividendIn), .divisorIn(divisorIn),
    .quotientReg(quotientReg), .divZeroReg(divZeroReg), .remReg(remReg),
    .heldDividend(heldDividend), .heldDivisor(heldDivisor)
  );

  assign resultLoad = strobes.resultLoad;
  assign quotient   = outDriven ? quotientReg : '0;
  assign divZero    = outDriven & divZeroReg;
  assign remNonZero = outDriven & remReg;
endmodule

// File: rtl/pipe_sdiv_checker.sv
module pipe_sdiv_checker
  import sdiv_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic [DIVIDEND_W-1:0] dividendIn,
  input logic                  dividendLoadN,
  input logic [DIVISOR_W-1:0]  divisorIn,
  input logic                  divisorLoadN,
  input logic                  outEnN,
  input logic [DIVIDEND_W-1:0] heldDividend,
  input logic [DIVISOR_W-1:0]  heldDivisor,
  input logic                  resultLoad,
  input logic                  outDriven,
  input logic [DIVIDEND_W-1:0] quotient,
  input logic                  divZero,
  input logic                  remNonZero
);
  assert_dividend_hold_R1: assert property (@(posedge clk) disable iff (rst)
    dividendLoadN |=> $stable(heldDividend));
  assert_dividend_load_R1: assert property (@(posedge clk) disable iff (rst)
    !dividendLoadN |=> heldDividend == $past(dividendIn));
  assert_divisor_hold_R2: assert property (@(posedge clk) disable iff (rst)
    divisorLoadN |=> $stable(heldDivisor));
  assert_divisor_load_R2: assert property (@(posedge clk) disable iff (rst)
    !divisorLoadN |=> heldDivisor == $past(divisorIn));
  assert_enable_on_R9: assert property (@(posedge clk) disable iff (rst)
    !outEnN |=> outDriven);
  assert_enable_off_R9: assert property (@(posedge clk) disable iff (rst)
    outEnN |=> !outDriven);
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !resultLoad |=> (quotient == '0 && !divZero && !remNonZero));
endmodule

bind pipe_sdiv pipe_sdiv_checker u_chk (
  .clk(clk), .rst(rst), .dividendIn(dividendIn), .dividendLoadN(dividendLoadN),
  .divisorIn(divisorIn), .divisorLoadN(divisorLoadN), .outEnN(outEnN),
  .heldDividend(heldDividend), .heldDivisor(heldDivisor), .resultLoad(resultLoad),
  .outDriven(outDriven), .quotient(quotient), .divZero(divZero), .remNonZero(remNonZero)
);

// File: tb/pipe_sdiv_bench.sv
module pipe_sdiv_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 19;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dividendIn = '0;
  logic        dividendLoadN = 1'b1;
  logic [15:0] divisorIn = '0;
  logic        divisorLoadN = 1'b1;
  logic        outEnN = 1'b0;
  logic [31:0] quotient;
  logic        divZero, remNonZero, outDriven;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string curTag = "R10";

  // reference model state
  logic [31:0] mA = '0;
  logic [15:0] mB = '0;
  logic        mOe = 1'b1;
  logic        eV [LAT];
  logic [31:0] eQ [LAT];
  logic        eDz [LAT];
  logic        eRem [LAT];
  string       eTag [LAT];
  logic        oV = 0;
  logic [31:0] oQ = '0;
  logic        oDz = 0, oRem = 0;
  string       oTag = "R10";

  pipe_sdiv u_pipe_sdiv (
    .clk(clk), .rst(rst), .dividendIn(dividendIn), .dividendLoadN(dividendLoadN),
    .divisorIn(divisorIn), .divisorLoadN(divisorLoadN), .outEnN(outEnN),
    .quotient(quotient), .divZero(divZero), .remNonZero(remNonZero), .outDriven(outDriven)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    longint sa, sb, q;
    if (rst) begin
      mA = '0; mB = '0; mOe = 1'b1; oV = 0;
      for (int k = 0; k < LAT; k++) eV[k] = 0;
    end else begin
      mOe = outEnN;
      if (!dividendLoadN) mA = dividendIn;
      if (!divisorLoadN)  mB = divisorIn;
      oV = eV[LAT-1]; oQ = eQ[LAT-1]; oDz = eDz[LAT-1]; oRem = eRem[LAT-1]; oTag = eTag[LAT-1];
      for (int k = LAT-1; k > 0; k--) begin
        eV[k] = eV[k-1]; eQ[k] = eQ[k-1]; eDz[k] = eDz[k-1]; eRem[k] = eRem[k-1]; eTag[k] = eTag[k-1];
      end
      sa = longint'($signed(mA));
      sb = longint'($signed(mB));
      eV[0] = 1; eTag[0] = curTag;
      if (sb == 0) begin
        eDz[0] = 1; eQ[0] = '0; eRem[0] = 0;
      end else begin
        q = sa / sb;
        eDz[0] = 0; eQ[0] = q[31:0]; eRem[0] = ((sa % sb) != 0);
      end
    end
  endtask

  task automatic compare();
    check(outDriven == !mOe, "R9", "outDriven", 32'(outDriven), 32'(!mOe));
    if (mOe) begin
      check(quotient == 0 && !divZero && !remNonZero, "R9", "undriven bus not zero",
            quotient, 32'h0);
    end else if (!oV) begin
      check(quotient == 0 && !divZero && !remNonZero, oTag, "empty pipeline not zero",
            quotient, 32'h0);
    end else if (oDz) begin
      check(divZero == 1'b1, oTag, "divZero (R6)", 32'(divZero), 32'h1);
    end else begin
      check(divZero == 1'b0, oTag, "divZero (R6)", 32'(divZero), 32'h0);
      check(quotient == oQ, oTag, "quotient (R4)", quotient, oQ);
      check(remNonZero == oRem, oTag, "remNonZero (R5)", 32'(remNonZero), 32'(oRem));
    end
  endtask

  task automatic cycle(input logic [31:0] a, input logic aLdN,
                       input logic [15:0] b, input logic bLdN);
    dividendIn = a; dividendLoadN = aLdN; divisorIn = b; divisorLoadN = bLdN;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compare();
  endtask

  function automatic logic [15:0] nzDivisor();
    logic [15:0] b;
    do b = 16'($urandom); while (b == 0);
    return b;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stimulus
    for (int k = 0; k < LAT; k++) begin eV[k] = 0; eQ[k] = '0; eDz[k] = 0; eRem[k] = 0; eTag[k] = "R10"; end
    @(negedge clk);
    rst = 1'b1;
    repeat (3) cycle(32'h1234, 1'b0, 16'h5, 1'b0);
    // R10: reset state
    check(outDriven == 1'b0 && quotient == 0 && !divZero && !remNonZero, "R10",
          "reset state", {quotient[30:0], outDriven}, 32'h0);
    rst = 1'b0;

    // R10: fill with reset-cleared operands, outputs zero until the first result
    curTag = "R10";
    repeat (LAT + 4) cycle(32'hdead_beef, 1'b1, 16'h7777, 1'b1);

    // R4: mixed signs, stream
    curTag = "R4";
    repeat (40) cycle($urandom, 1'b0, nzDivisor(), 1'b0);

    // R5: exact multiples and near multiples
    curTag = "R5";
    for (int i = 0; i < 30; i++) begin
      logic [15:0] b = nzDivisor();
      int k = int'($signed(16'($urandom)));
      int a = int'($signed(b)) * k + ((i % 2 == 1) ? (i % 5) + 1 : 0);
      cycle(32'(a), 1'b0, b, 1'b0);
    end

    // R6: zero divisor, any dividend
    curTag = "R6";
    repeat (10) cycle($urandom, 1'b0, 16'h0000, 1'b0);

    // R7: negative full scale by minus one
    curTag = "R7";
    cycle(32'h8000_0000, 1'b0, 16'hFFFF, 1'b0);
    cycle(32'h8000_0000, 1'b0, 16'h0001, 1'b0);
    cycle(32'h7FFF_FFFF, 1'b0, 16'h8000, 1'b0);
    cycle(32'h8000_0000, 1'b0, 16'hFFFF, 1'b0);

    // R8: magnitude of dividend below divisor
    curTag = "R8";
    for (int i = 0; i < 20; i++) begin
      int bm = 256 + int'($urandom % 30000);
      int am = (i == 0) ? 0 : int'($urandom % bm);
      int bs = ($urandom % 2) ? -bm : bm;
      int as = ($urandom % 2) ? -am : am;
      cycle(32'(as), 1'b0, 16'(bs), 1'b0);
    end

    // R2: constant divisor held while dividends stream
    curTag = "R2";
    cycle($urandom, 1'b0, 16'hFFF9, 1'b0);
    repeat (20) cycle($urandom, 1'b0, nzDivisor(), 1'b1);

    // R1: held dividend while divisors stream
    curTag = "R1";
    cycle(32'h8765_4321, 1'b0, nzDivisor(), 1'b0);
    repeat (20) cycle($urandom, 1'b1, nzDivisor(), 1'b0);

    // R9: output enable toggling in a dense stream
    curTag = "R9";
    for (int i = 0; i < 30; i++) begin
      outEnN = 1'($urandom);
      cycle($urandom, 1'b0, nzDivisor(), 1'b0);
    end
    outEnN = 1'b0;

    // R3: one operation, then hold, latency and cadence
    curTag = "R3";
    cycle(32'hFFFF_FF9C, 1'b0, 16'h0007, 1'b0);
    repeat (LAT + 6) cycle($urandom, 1'b1, 16'($urandom), 1'b1);
    repeat (LAT + 3) cycle($urandom, 1'b0, nzDivisor(), 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule